// File: doc/BRIEF.md
# Partitioned Multi-Channel Transfer Buffer

This block owns one 4608-byte data store shared by six transfer channels. Software carves the store into regions at run time, one region per channel, and sets each channel's endpoint number, largest packet size, direction and transfer kind. Each region behaves as a circular byte queue. The queue has its own read and write offsets, and both offsets wrap inside the region.

Which side writes a region depends on the channel direction. A device-to-host (IN) channel is filled by the bus side and drained by the CPU side. A host-to-device (OUT) channel is filled by the CPU side and drained by the bus side. The block raises a per-channel ready flag when a whole packet can be moved: enough free room for an IN channel, or enough stored bytes for an OUT channel. The transaction engine can therefore run transfers without any CPU action per packet. A round-robin grant picks one ready channel per cycle and presents that channel's endpoint, kind and direction.

Top module: `xfifo_top`

## Requirements
- R1: After reset, readyVec, errVec, grantVec and cfgErr are all zero.
- R2: Bytes leave a region in the order they entered, including when the offsets wrap past the region end back to its base.
- R3: A push into a full region or a pop from an empty region is dropped and leaves the stored data unchanged. It sets that channel's errVec bit, which stays set until the channel is configured again.
- R4: An IN channel (cfgDirIn=1) with a nonzero size is ready whenever its free bytes (size minus stored) are at least its packet size.
- R5: An OUT channel (cfgDirIn=0) is ready once its stored bytes reach its nonzero packet size.
- R6: A short commit on an OUT channel makes it ready while it holds at least one byte. The commit lapses when the region drains to empty.
- R7: Only the filling side may push and only the draining side may pop: bus pushes and CPU pops for IN, CPU pushes and bus pops for OUT. An access from the wrong side is dropped and sets errVec.
- R8: A configuration write to a channel empties its region and clears its error bit and any pending short commit. Bytes stored before the write are discarded.
- R9: cfgErr rises one cycle after the configuration whenever two nonzero regions overlap or any region ends past byte 4608. It falls again once the layout is legal.
- R10: grantVec is one-hot or zero, is always a subset of readyVec, and is nonzero when any channel is ready. With several channels ready, successive grants rotate through them.
- R11: Kind codes are 0 control, 1 bulk, 2 interrupt and 3 isochronous. Channel 0 is always control and channel 1 always bulk. Channels 2 to 5 store a requested control kind as bulk. grantEp, grantKind and grantDirIn show the granted channel's settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgCh | input | 3 | Channel being configured |
| cfgBase | input | 13 | Region start byte |
| cfgSize | input | 13 | Region length in bytes |
| cfgEp | input | 4 | Endpoint number |
| cfgMps | input | 11 | Largest packet size in bytes |
| cfgDirIn | input | 1 | 1 = IN, 0 = OUT |
| cfgKind | input | 2 | Requested transfer kind |
| cpuPush | input | 1 | CPU-side byte push |
| cpuPop | input | 1 | CPU-side byte pop |
| cpuCh | input | 3 | CPU-side channel select |
| cpuWrData | input | 8 | CPU-side push byte |
| cpuRdData | output | 8 | Head byte of the CPU-selected region |
| busPush | input | 1 | Bus-side byte push |
| busPop | input | 1 | Bus-side byte pop |
| busCh | input | 3 | Bus-side channel select |
| busWrData | input | 8 | Bus-side push byte |
| busRdData | output | 8 | Head byte of the bus-selected region |
| commitShort | input | 1 | Short-packet commit strobe |
| commitCh | input | 3 | Channel for the commit |
| readyVec | output | 6 | Per-channel transaction ready |
| errVec | output | 6 | Sticky per-channel access error |
| cfgErr | output | 1 | Region layout error |
| grantVec | output | 6 | One-hot round-robin grant |
| grantEp | output | 4 | Endpoint of granted channel |
| grantKind | output | 2 | Kind of granted channel |
| grantDirIn | output | 1 | Direction of granted channel |

## Verification
The OUT path is driven with pushes that stop one byte short of a packet, reach a packet exactly, and continue past the region end. This separates the ready threshold from plain non-emptiness and shows that the wrap keeps the byte order. The IN path moves free space across the threshold in both directions, and wrong-side and full or empty accesses show that drops leave the data intact. Several IN channels are then made ready together to show that the grant rotates rather than favouring one channel. Region layouts with an overlap, an overrun past 4608 bytes and a legal placement exercise the configuration check.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  localparam int NUM_CH    = 6;
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int BUF_DEPTH = 4608;
  localparam int ADDR_W    = $clog2(BUF_DEPTH);
  localparam int FILL_W    = ADDR_W + 1;
  localparam int MPS_W     = 11;
  localparam int EP_W      = 4;
  localparam int DATA_W    = 8;

  typedef enum logic [1:0] {
    KIND_CTRL = 2'd0,
    KIND_BULK = 2'd1,
    KIND_INTR = 2'd2,
    KIND_ISO  = 2'd3
  } xferKind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] size;
    logic [EP_W-1:0]   ep;
    logic [MPS_W-1:0]  mps;
    logic              dirIn;
    xferKind_e         kind;
  } chanCfg_t;

  typedef struct packed {
    logic              cpuWe;
    logic [ADDR_W-1:0] cpuWrAddr;
    logic              busWe;
    logic [ADDR_W-1:0] busWrAddr;
    logic [ADDR_W-1:0] cpuRdAddr;
    logic [ADDR_W-1:0] busRdAddr;
  } memStrobe_t;
endpackage

// File: rtl/xfifo_data.sv
module xfifo_data
  import xfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [DATA_W-1:0] busRdData
);
  logic [DATA_W-1:0] mem [BUF_DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.cpuWe) mem[strobe.cpuWrAddr] <= cpuWrData;
    if (strobe.busWe) mem[strobe.busWrAddr] <= busWrData;
  end

  assign cpuRdData = mem[strobe.cpuRdAddr];
  assign busRdData = mem[strobe.busRdAddr];

  // R7: the two write ports never target the same byte
  p_single_writer_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cpuWe && strobe.busWe) |-> (strobe.cpuWrAddr != strobe.busWrAddr));
endmodule

// File: rtl/xfifo_ctrl.sv
module xfifo_ctrl
  import xfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  chanCfg_t          cfgIn,
  input  logic              cpuPush,
  input  logic              cpuPop,
  input  logic [CH_W-1:0]   cpuCh,
  input  logic              busPush,
  input  logic              busPop,
  input  logic [CH_W-1:0]   busCh,
  input  logic              commitShort,
  input  logic [CH_W-1:0]   commitCh,
  output memStrobe_t        strobe,
  output logic [NUM_CH-1:0] readyVec,
  output logic [NUM_CH-1:0] errVec,
  output logic              cfgErr,
  output chanCfg_t          cfgArr [NUM_CH]
);
  logic [ADDR_W-1:0] wrOff [NUM_CH];
  logic [ADDR_W-1:0] rdOff [NUM_CH];
  logic [FILL_W-1:0] fill  [NUM_CH];
  logic [NUM_CH-1:0] pend, pushOk, popOk, badOp;
  logic              layoutBad;

  function automatic xferKind_e fixKind(input int ch, input xferKind_e req);
    if (ch == 0) return KIND_CTRL;
    if (ch == 1) return KIND_BULK;
    return (req == KIND_CTRL) ? KIND_BULK : req;
  endfunction

  function automatic logic [FILL_W-1:0] absAddr(input logic [ADDR_W-1:0] b,
                                                input logic [ADDR_W-1:0] o);
    return {1'b0, b} + {1'b0, o};
  endfunction

  // per-channel access legality
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      logic cSel, bSel, isFull, isEmpty, fillerPush, drainPop, wrongSide;
      cSel       = (cpuCh == CH_W'(c));
      bSel       = (busCh == CH_W'(c));
      isFull     = fill[c] >= {1'b0, cfgArr[c].size};
      isEmpty    = (fill[c] == '0);
      fillerPush = cfgArr[c].dirIn ? (busPush && bSel) : (cpuPush && cSel);
      drainPop   = cfgArr[c].dirIn ? (cpuPop && cSel) : (busPop && bSel);
      wrongSide  = cfgArr[c].dirIn ? ((cpuPush && cSel) || (busPop && bSel))
                                   : ((busPush && bSel) || (cpuPop && cSel));
      pushOk[c]  = fillerPush && !isFull;
      popOk[c]   = drainPop && !isEmpty;
      badOp[c]   = wrongSide || (fillerPush && isFull) || (drainPop && isEmpty);
    end
  end

  // memory strobes towards the datapath
  always_comb begin
    strobe = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      logic [FILL_W-1:0] rdA, wrA;
      rdA = absAddr(cfgArr[c].base, rdOff[c]);
      wrA = absAddr(cfgArr[c].base, wrOff[c]);
      if (cpuCh == CH_W'(c)) begin
        if (rdA < FILL_W'(BUF_DEPTH)) strobe.cpuRdAddr = rdA[ADDR_W-1:0];
        if (pushOk[c] && !cfgArr[c].dirIn && wrA < FILL_W'(BUF_DEPTH)) begin
          strobe.cpuWe     = 1'b1;
          strobe.cpuWrAddr = wrA[ADDR_W-1:0];
        end
      end
      if (busCh == CH_W'(c)) begin
        if (rdA < FILL_W'(BUF_DEPTH)) strobe.busRdAddr = rdA[ADDR_W-1:0];
        if (pushOk[c] && cfgArr[c].dirIn && wrA < FILL_W'(BUF_DEPTH)) begin
          strobe.busWe     = 1'b1;
          strobe.busWrAddr = wrA[ADDR_W-1:0];
        end
      end
    end
  end

  // region state
  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (!rstN) begin
        cfgArr[c]      <= '0;
        cfgArr[c].kind <= fixKind(c, KIND_CTRL);
        wrOff[c]       <= '0;
        rdOff[c]       <= '0;
        fill[c]        <= '0;
        pend[c]        <= 1'b0;
        errVec[c]      <= 1'b0;
      end else if (cfgWe && cfgCh == CH_W'(c)) begin
        cfgArr[c]      <= cfgIn;
        cfgArr[c].kind <= fixKind(c, cfgIn.kind);
        wrOff[c]       <= '0;
        rdOff[c]       <= '0;
        fill[c]        <= '0;
        pend[c]        <= 1'b0;
        errVec[c]      <= 1'b0;
      end else begin
        logic [FILL_W-1:0] nextFill;
        nextFill = fill[c] + FILL_W'(pushOk[c]) - FILL_W'(popOk[c]);
        if (pushOk[c])
          wrOff[c] <= (wrOff[c] == cfgArr[c].size - 1'b1) ? '0 : wrOff[c] + 1'b1;
        if (popOk[c])
          rdOff[c] <= (rdOff[c] == cfgArr[c].size - 1'b1) ? '0 : rdOff[c] + 1'b1;
        fill[c]   <= nextFill;
        errVec[c] <= errVec[c] | badOp[c];
        if (commitShort && commitCh == CH_W'(c) && !cfgArr[c].dirIn) pend[c] <= 1'b1;
        else if (nextFill == '0) pend[c] <= 1'b0;
      end
    end
  end

  // readiness against the packet size
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      logic [FILL_W-1:0] freeB, mpsX;
      freeB = {1'b0, cfgArr[c].size} - fill[c];
      mpsX  = FILL_W'(cfgArr[c].mps);
      if (cfgArr[c].size == '0) readyVec[c] = 1'b0;
      else if (cfgArr[c].dirIn) readyVec[c] = freeB >= mpsX;
      else readyVec[c] = ((mpsX != '0) && fill[c] >= mpsX) || (pend[c] && fill[c] != '0);
    end
  end

  // region layout check
  always_comb begin
    layoutBad = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cfgArr[i].size != '0) begin
        if (absAddr(cfgArr[i].base, cfgArr[i].size) > FILL_W'(BUF_DEPTH)) layoutBad = 1'b1;
        for (int j = i + 1; j < NUM_CH; j++) begin
          if (cfgArr[j].size != '0 &&
              {1'b0, cfgArr[i].base} < absAddr(cfgArr[j].base, cfgArr[j].size) &&
              {1'b0, cfgArr[j].base} < absAddr(cfgArr[i].base, cfgArr[i].size))
            layoutBad = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgErr <= 1'b0;
    else       cfgErr <= layoutBad;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
      fill[g] <= {1'b0, cfgArr[g].size});
    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
      (errVec[g] && !(cfgWe && cfgCh == CH_W'(g))) |=> errVec[g]);
    p_reconf_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWe && cfgCh == CH_W'(g)) |=> (fill[g] == '0 && !errVec[g] && !pend[g]));
    p_wrong_side_r7: assert property (@(posedge clk) disable iff (!rstN)
      (cfgArr[g].dirIn && cpuPush && cpuCh == CH_W'(g) && !(cfgWe && cfgCh == CH_W'(g)))
      |=> errVec[g]);
  end
endmodule

// File: rtl/xfifo_rr.sv
module xfifo_rr
  import xfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] readyVec,
  output logic [NUM_CH-1:0] grantVec,
  output logic [CH_W-1:0]   grantIdx
);
  logic [CH_W-1:0] lastIdx;

  always_comb begin
    logic found;
    found    = 1'b0;
    grantVec = '0;
    grantIdx = '0;
    for (int k = 1; k <= NUM_CH; k++) begin
      int idx;
      idx = (int'(lastIdx) + k) % NUM_CH;
      if (!found && readyVec[idx]) begin
        found         = 1'b1;
        grantVec[idx] = 1'b1;
        grantIdx      = CH_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          lastIdx <= CH_W'(NUM_CH - 1);
    else if (|readyVec) lastIdx <= grantIdx;
  end

  p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));
  p_grant_subset_r10: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec & ~readyVec) == '0);
  p_grant_live_r10: assert property (@(posedge clk) disable iff (!rstN)
    (|readyVec) |-> (|grantVec));
endmodule

// File: rtl/xfifo_top.sv
module xfifo_top
  import xfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgSize,
  input  logic [EP_W-1:0]   cfgEp,
  input  logic [MPS_W-1:0]  cfgMps,
  input  logic              cfgDirIn,
  input  logic [1:0]        cfgKind,
  input  logic              cpuPush,
  input  logic              cpuPop,
  input  logic [CH_W-1:0]   cpuCh,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              busPush,
  input  logic              busPop,
  input  logic [CH_W-1:0]   busCh,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              commitShort,
  input  logic [CH_W-1:0]   commitCh,
  output logic [NUM_CH-1:0] readyVec,
  output logic [NUM_CH-1:0] errVec,
  output logic              cfgErr,
  output logic [NUM_CH-1:0] grantVec,
  output logic [EP_W-1:0]   grantEp,
  output logic [1:0]        grantKind,
  output logic              grantDirIn
);
  chanCfg_t   cfgIn;
  chanCfg_t   cfgArr [NUM_CH];
  memStrobe_t strobe;
  logic [CH_W-1:0] grantIdx;

  assign cfgIn = '{base: cfgBase, size: cfgSize, ep: cfgEp, mps: cfgMps,
                   dirIn: cfgDirIn, kind: xferKind_e'(cfgKind)};

  xfifo_ctrl u_ctrl (
    .clk, .rstN, .cfgWe, .cfgCh, .cfgIn,
    .cpuPush, .cpuPop, .cpuCh, .busPush, .busPop, .busCh,
    .commitShort, .commitCh,
    .strobe, .readyVec, .errVec, .cfgErr, .cfgArr
  );

  xfifo_data u_data (
    .clk, .rstN, .strobe, .cpuWrData, .busWrData, .cpuRdData, .busRdData
  );

  xfifo_rr u_rr (
    .clk, .rstN, .readyVec, .grantVec, .grantIdx
  );

  always_comb begin
    grantEp    = '0;
    grantKind  = '0;
    grantDirIn = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (grantIdx == CH_W'(c) && |grantVec) begin
        grantEp    = cfgArr[c].ep;
        grantKind  = cfgArr[c].kind;
        grantDirIn = cfgArr[c].dirIn;
      end
    end
  end
endmodule

// File: tb/sim_xfifo_top.sv
module sim_xfifo_top;
  logic clk = 1'b0;
  logic rstN;
  logic cfgWe = 0, cfgDirIn = 0, cpuPush = 0, cpuPop = 0, busPush = 0, busPop = 0, commitShort = 0;
  logic [2:0] cfgCh = 0, cpuCh = 0, busCh = 0, commitCh = 0;
  logic [12:0] cfgBase = 0, cfgSize = 0;
  logic [3:0] cfgEp = 0;
  logic [10:0] cfgMps = 0;
  logic [1:0] cfgKind = 0;
  logic [7:0] cpuWrData = 0, busWrData = 0;
  logic [7:0] cpuRdData, busRdData;
  logic [5:0] readyVec, errVec, grantVec;
  logic cfgErr, grantDirIn;
  logic [3:0] grantEp;
  logic [1:0] grantKind;

  int nChecks = 0, nErr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xfifo_top u0 (.*);

  task automatic checkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input int ch, input int base, input int size, input int ep,
                          input int mps, input bit dirIn, input int kind);
    @(negedge clk);
    cfgWe = 1; cfgCh = 3'(ch); cfgBase = 13'(base); cfgSize = 13'(size);
    cfgEp = 4'(ep); cfgMps = 11'(mps); cfgDirIn = dirIn; cfgKind = 2'(kind);
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic cpuPushB(input int ch, input int d);
    @(negedge clk); cpuPush = 1; cpuCh = 3'(ch); cpuWrData = 8'(d);
    @(negedge clk); cpuPush = 0;
  endtask

  task automatic busPushB(input int ch, input int d);
    @(negedge clk); busPush = 1; busCh = 3'(ch); busWrData = 8'(d);
    @(negedge clk); busPush = 0;
  endtask

  task automatic busPopB(input int ch, input int exp, input string req);
    @(negedge clk); busCh = 3'(ch); #1;
    checkEq(req, busRdData, exp);
    busPop = 1;
    @(negedge clk); busPop = 0;
  endtask

  task automatic cpuPopB(input int ch, input int exp, input string req);
    @(negedge clk); cpuCh = 3'(ch); #1;
    checkEq(req, cpuRdData, exp);
    cpuPop = 1;
    @(negedge clk); cpuPop = 0;
  endtask

  task automatic testReset;
    @(negedge clk);
    checkEq("R1 readyVec", readyVec, 0);
    checkEq("R1 errVec", errVec, 0);
    checkEq("R1 grantVec", grantVec, 0);
    checkEq("R1 cfgErr", cfgErr, 0);
  endtask

  task automatic testOutThreshold;
    cfgWrite(2, 0, 8, 5, 4, 0, 0);
    for (int i = 0; i < 3; i++) cpuPushB(2, 8'h10 + i);
    checkEq("R5 below packet", readyVec[2], 0);
    cpuPushB(2, 8'h13);
    checkEq("R5 full packet", readyVec[2], 1);
    checkEq("R10 single grant", grantVec, 6'b000100);
    checkEq("R11 control coerced to bulk", grantKind, 1);
    checkEq("R11 grant endpoint", grantEp, 5);
    checkEq("R11 grant direction", grantDirIn, 0);
  endtask

  task automatic testWrapOrder;
    for (int i = 0; i < 4; i++) busPopB(2, 8'h10 + i, "R2 order");
    checkEq("R5 drained", readyVec[2], 0);
    for (int i = 0; i < 6; i++) cpuPushB(2, 8'h20 + i);
    for (int i = 0; i < 6; i++) busPopB(2, 8'h20 + i, "R2 wrap order");
  endtask

  task automatic testFullEmpty;
    for (int i = 0; i < 8; i++) cpuPushB(2, 8'h30 + i);
    checkEq("R3 no error before overflow", errVec[2], 0);
    cpuPushB(2, 8'hFF);
    checkEq("R3 overflow flag", errVec, 6'b000100);
    for (int i = 0; i < 8; i++) busPopB(2, 8'h30 + i, "R3 data kept after drop");
    @(negedge clk); busCh = 3'd2; busPop = 1;
    @(negedge clk); busPop = 0;
    checkEq("R3 sticky after underflow", errVec[2], 1);
    cpuPushB(2, 8'h50);
    cpuPushB(2, 8'h51);
    cfgWrite(2, 0, 8, 5, 4, 0, 0);
    checkEq("R8 error cleared", errVec[2], 0);
    checkEq("R8 ready cleared", readyVec[2], 0);
    cpuPushB(2, 8'h41);
    busPopB(2, 8'h41, "R8 old bytes discarded");
  endtask

  task automatic testInSide;
    cfgWrite(3, 16, 8, 3, 4, 1, 2);
    checkEq("R4 empty IN ready", readyVec, 6'b001000);
    for (int i = 0; i < 5; i++) busPushB(3, 8'h60 + i);
    checkEq("R4 free below packet", readyVec[3], 0);
    cpuPopB(3, 8'h60, "R2 IN order");
    checkEq("R4 free reaches packet", readyVec[3], 1);
    cpuPushB(3, 8'hAA);
    checkEq("R7 wrong-side push flagged", errVec[3], 1);
    cpuPopB(3, 8'h61, "R7 wrong-side push dropped");
  endtask

  task automatic testShortCommit;
    cpuPushB(2, 8'h70);
    cpuPushB(2, 8'h71);
    checkEq("R6 partial not ready", readyVec[2], 0);
    @(negedge clk); commitShort = 1; commitCh = 3'd2;
    @(negedge clk); commitShort = 0;
    checkEq("R6 commit ready", readyVec[2], 1);
    busPopB(2, 8'h70, "R6 data");
    busPopB(2, 8'h71, "R6 data");
    checkEq("R6 commit lapses", readyVec[2], 0);
  endtask

  task automatic testRoundRobin;
    logic [5:0] seen, prev;
    cfgWrite(4, 32, 8, 4, 2, 1, 3);
    cfgWrite(5, 48, 8, 9, 2, 1, 3);
    checkEq("R4 three IN ready", readyVec, 6'b111000);
    seen = 0; prev = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkEq("R10 one-hot", $countones(grantVec), 1);
      checkEq("R10 subset", grantVec & ~readyVec, 0);
      if (i > 0) checkEq("R10 rotates", (grantVec == prev) ? 1 : 0, 0);
      if (grantVec == 6'b100000) begin
        checkEq("R11 iso kind kept", grantKind, 3);
        checkEq("R11 grant endpoint ch5", grantEp, 9);
      end
      seen |= grantVec;
      prev = grantVec;
    end
    checkEq("R10 all served", seen, 6'b111000);
  endtask

  task automatic testLayout;
    checkEq("R9 legal layout", cfgErr, 0);
    cfgWrite(0, 4, 8, 0, 8, 0, 3);
    @(negedge clk);
    checkEq("R9 overlap", cfgErr, 1);
    cfgWrite(0, 4000, 700, 0, 8, 0, 3);
    @(negedge clk);
    checkEq("R9 past end", cfgErr, 1);
    cfgWrite(0, 3000, 600, 0, 8, 0, 3);
    @(negedge clk);
    checkEq("R9 fixed", cfgErr, 0);
  endtask

  initial begin
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testOutThreshold();
    testWrapOrder();
    testFullEmpty();
    testInSide();
    testShortCommit();
    testRoundRobin();
    testLayout();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nErr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule